// File: doc/BRIEF.md
# SPI Command Engine with Device-Busy Handshake

This block is an SPI host that issues opcode-based commands to a peripheral radio device and paces itself on the device's BUSY line. A client presents a 16-bit opcode, a count of parameter bytes that it has first written into a small internal buffer, and a count of expected response bytes. The engine waits for BUSY low and sends the opcode, most significant byte first, followed by the parameters, all in one chip-select frame. For a write command it then waits for BUSY low again before it reports completion. For a read command it releases chip select, waits for BUSY low, and opens a second frame of all-zero bytes. It drops the first byte that comes back, because the device returns status there. The remaining bytes go out on a byte stream, one valid strobe per byte.

Every BUSY wait has a bounded length. When that limit runs out, the command is abandoned and a timeout pulse replaces the completion pulse. The engine also produces the device's active-low reset pulse. This pulse runs after the engine's own reset and on request, with a hold time and a settle time given in milliseconds and converted to clock cycles from a clock-frequency parameter. No command is accepted until the settle time has passed.

Top module: `spi_cmd_engine`

## Requirements
- R1: After `rst_n` rises, or after a `dev_reset_req` pulse while idle, `dev_rst_n` is held low for CLK_KHZ*RST_LOW_MS cycles (±1). It then stays high for a further CLK_KHZ*RST_WAIT_MS cycles (±1) before `cmd_ready` rises. `cmd_ready` is low whenever `dev_rst_n` is low.
- R2: A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when the engine is idle and the reset sequence has finished. While `cmd_ready` is low, a held `cmd_valid` starts no frame.
- R3: The first frame carries the opcode's bits 15:8, then its bits 7:0, then `cmd_nparam` bytes from parameter buffer addresses 0, 1, 2 and upward.
- R4: `spi_nss` falls only after `dev_busy`, seen through the input synchroniser, has been low. It never falls while BUSY is held high.
- R5: For a command with `cmd_nresp` = 0, `cmd_done` pulses only after `dev_busy` has been seen low following the end of the frame.
- R6: For `cmd_nresp` = N > 0, a second frame follows. It comes after `spi_nss` has been high for at least 2*CLK_DIV cycles and BUSY has been seen low, and it carries N+1 bytes of 0x00.
- R7: In the second frame the first byte received is discarded. The following N bytes appear on `rsp_data` with one `rsp_valid` pulse each, in the order received. The last strobe comes in the same cycle as `cmd_done`.
- R8: The SPI runs in mode 0. `spi_sck` is low whenever `spi_nss` is high, and MOSI does not change at a rising SCK edge. Bytes are sent and received MSB first, and MISO is sampled on rising edges. Each SCK half-period is CLK_DIV clocks.
- R9: If BUSY stays high for BUSY_LIMIT cycles of any wait, `busy_timeout` pulses and the engine returns to idle. A timeout in the wait before a frame leaves `spi_nss` high, so no frame starts. A timeout before the read frame produces no response bytes.
- R10: Each accepted command ends in exactly one pulse, either `cmd_done` or `busy_timeout`, never both.
- R11: `cmd_nparam` = 0 gives a two-byte frame that carries only the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_reset_req | input | 1 | Request a new device reset pulse (taken while idle) |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle and device out of reset |
| cmd_opcode | input | 16 | Command opcode |
| cmd_nparam | input | $clog2(MAX_PARAMS+1) | Parameter bytes to send |
| cmd_nresp | input | $clog2(MAX_RESP+1) | Response bytes wanted (0 = write command) |
| prm_we | input | 1 | Parameter buffer write strobe |
| prm_addr | input | $clog2(MAX_PARAMS) | Parameter buffer address |
| prm_wdata | input | 8 | Parameter byte |
| rsp_valid | output | 1 | Response byte strobe |
| rsp_data | output | 8 | Response byte |
| cmd_done | output | 1 | Command finished pulse |
| busy_timeout | output | 1 | BUSY wait expired pulse |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data to device |
| spi_miso | input | 1 | SPI data from device |
| spi_nss | output | 1 | Active-low chip select |
| dev_busy | input | 1 | Device BUSY, high while the device is occupied |
| dev_rst_n | output | 1 | Active-low device reset |

## Verification
On a read command, the strobe for the last response byte and the completion pulse come from the same shifter event, so they land in the same cycle. The completion pulse and the timeout pulse come from different waits and must never meet. The bench sweeps every pairing of parameter and response counts in a small configuration, with device BUSY windows of varied length after each frame. At the cycle where completion is seen, it judges whether the full response stream has already arrived. It also counts pulses per command to confirm that only one of completion or timeout occurs, including runs where BUSY is held long enough to force a timeout before the first frame and before the read frame.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT_PRE,
      ST_SEND,
      ST_GAP,
      ST_WAIT_RD,
      ST_READ,
      ST_WAIT_POST
   } eng_state_t;

   localparam logic [7:0] FILL_BYTE = 8'h00;

endpackage

// File: rtl/spicmd_shifter.sv
module spicmd_shifter #(
   parameter int unsigned CLK_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   output logic       act,
   output logic       done,
   output logic [7:0] rx,
   output logic       sck,
   output logic       mosi,
   input  logic       miso
);
   localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   logic [CW-1:0] cnt;
   logic [2:0]    bitn;
   logic [7:0]    txs;
   logic [7:0]    rxs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
         bitn <= '0;
         txs  <= '0;
         rxs  <= '0;
         sck  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !act) begin
            act  <= 1'b1;
            txs  <= tx;
            cnt  <= '0;
            bitn <= '0;
            sck  <= 1'b0;
         end else if (act) begin
            if (cnt == CW'(CLK_DIV - 1)) begin
               cnt <= '0;
               if (!sck) begin
                  sck <= 1'b1;
                  rxs <= {rxs[6:0], miso};
               end else begin
                  sck <= 1'b0;
                  if (bitn == 3'd7) begin
                     act  <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     bitn <= bitn + 3'd1;
                     txs  <= {txs[6:0], 1'b0};
                  end
               end
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   assign mosi = txs[7];
   assign rx   = rxs;

   AST_MOSI_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(mosi)); // R8

   AST_DONE_AFTER_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !sck); // R8

endmodule

// File: rtl/spicmd_rstgen.sv
module spicmd_rstgen #(
   parameter int unsigned LOW_CYC  = 1000,
   parameter int unsigned WAIT_CYC = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic dev_rst_n,
   output logic ready
);
   localparam int unsigned MAXC = (LOW_CYC > WAIT_CYC) ? LOW_CYC : WAIT_CYC;
   localparam int unsigned CW   = $clog2(MAXC + 1);

   typedef enum logic [1:0] {PH_HOLD, PH_SETTLE, PH_RUN} ph_t;

   ph_t           ph;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_HOLD;
         cnt <= '0;
      end else begin
         unique case (ph)
            PH_HOLD: begin
               if (cnt == CW'(LOW_CYC - 1)) begin
                  ph  <= PH_SETTLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            PH_SETTLE: begin
               if (cnt == CW'(WAIT_CYC - 1)) begin
                  ph  <= PH_RUN;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: begin
               if (req) begin
                  ph  <= PH_HOLD;
                  cnt <= '0;
               end
            end
         endcase
      end
   end

   assign dev_rst_n = (ph != PH_HOLD);
   assign ready     = (ph == PH_RUN);

   AST_REQ_STARTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req) |=> !dev_rst_n); // R1

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spicmd_pkg::*;
#(
   parameter int unsigned CLK_DIV     = 4,
   parameter int unsigned MAX_PARAMS  = 256,
   parameter int unsigned MAX_RESP    = 256,
   parameter int unsigned BUSY_LIMIT  = 1000000,
   parameter int unsigned CLK_KHZ     = 100000,
   parameter int unsigned RST_LOW_MS  = 10,
   parameter int unsigned RST_WAIT_MS = 20,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned PCW = $clog2(MAX_PARAMS + 1),
   localparam int unsigned RCW = $clog2(MAX_RESP + 1),
   localparam int unsigned PAW = (MAX_PARAMS > 1) ? $clog2(MAX_PARAMS) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           dev_reset_req,
   input  logic           cmd_valid,
   output logic           cmd_ready,
   input  logic [15:0]    cmd_opcode,
   input  logic [PCW-1:0] cmd_nparam,
   input  logic [RCW-1:0] cmd_nresp,
   input  logic           prm_we,
   input  logic [PAW-1:0] prm_addr,
   input  logic [7:0]     prm_wdata,
   output logic           rsp_valid,
   output logic [7:0]     rsp_data,
   output logic           cmd_done,
   output logic           busy_timeout,
   output logic           spi_sck,
   output logic           spi_mosi,
   input  logic           spi_miso,
   output logic           spi_nss,
   input  logic           dev_busy,
   output logic           dev_rst_n
);
   localparam int unsigned MAXB     = (MAX_PARAMS + 2 > MAX_RESP + 1) ? MAX_PARAMS + 2 : MAX_RESP + 1;
   localparam int unsigned IW       = $clog2(MAXB + 1);
   localparam int unsigned BCW      = $clog2(BUSY_LIMIT + 1);
   localparam int unsigned GAPC     = 2 * CLK_DIV;
   localparam int unsigned GW       = $clog2(GAPC + 1);
   localparam int unsigned LOW_CYC  = CLK_KHZ * RST_LOW_MS;
   localparam int unsigned WAIT_CYC = CLK_KHZ * RST_WAIT_MS;

   // elaboration-time parameter checks
   if (CLK_DIV < 1)                         begin : g_bad_div  $error("CLK_DIV must be at least 1"); end
   if (MAX_PARAMS < 1)                      begin : g_bad_prm  $error("MAX_PARAMS must be at least 1"); end
   if (MAX_RESP < 1)                        begin : g_bad_rsp  $error("MAX_RESP must be at least 1"); end
   if (BUSY_LIMIT < 2)                      begin : g_bad_lim  $error("BUSY_LIMIT must be at least 2"); end
   if (LOW_CYC < 1 || WAIT_CYC < 1)         begin : g_bad_rst  $error("reset timing rounds to zero cycles"); end
   if (SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_syn  $error("SYNC_STAGES must be 0, 2, 3 or 4"); end

   // BUSY input conditioning: bypass or flop chain
   logic busy_s;
   if (SYNC_STAGES == 0) begin : g_busy_direct
      assign busy_s = dev_busy;
   end else begin : g_busy_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2:0], dev_busy};
      end
      assign busy_s = chain[SYNC_STAGES-1];
   end

   // parameter buffer
   logic [7:0] pbuf [MAX_PARAMS];
   always_ff @(posedge clk) begin
      if (prm_we) pbuf[prm_addr] <= prm_wdata;
   end

   // device reset sequencer
   logic rst_ready;
   eng_state_t st;

   spicmd_rstgen #(.LOW_CYC(LOW_CYC), .WAIT_CYC(WAIT_CYC)) u_rstgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (dev_reset_req && (st == ST_IDLE)),
      .dev_rst_n (dev_rst_n),
      .ready     (rst_ready)
   );

   // byte shifter
   logic       sh_go, sh_act, sh_done;
   logic [7:0] sh_tx, sh_rx;

   spicmd_shifter #(.CLK_DIV(CLK_DIV)) u_shifter (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sh_go),
      .tx    (sh_tx),
      .act   (sh_act),
      .done  (sh_done),
      .rx    (sh_rx),
      .sck   (spi_sck),
      .mosi  (spi_mosi),
      .miso  (spi_miso)
   );

   // command sequencer
   logic [15:0]    op_q;
   logic [PCW-1:0] np_q;
   logic [RCW-1:0] nr_q;
   logic [IW-1:0]  idx, total;
   logic [BCW-1:0] bcnt;
   logic [GW-1:0]  gcnt;
   logic           bwait_hit;

   assign cmd_ready = (st == ST_IDLE) && rst_ready;
   assign total     = (st == ST_READ) ? (IW'(nr_q) + IW'(1)) : (IW'(np_q) + IW'(2));
   assign bwait_hit = (bcnt == BCW'(BUSY_LIMIT - 1));

   always_comb begin
      if (st == ST_READ)      sh_tx = FILL_BYTE;
      else if (idx == '0)     sh_tx = op_q[15:8];
      else if (idx == IW'(1)) sh_tx = op_q[7:0];
      else                    sh_tx = pbuf[PAW'(idx - IW'(2))];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         op_q         <= '0;
         np_q         <= '0;
         nr_q         <= '0;
         idx          <= '0;
         bcnt         <= '0;
         gcnt         <= '0;
         sh_go        <= 1'b0;
         spi_nss      <= 1'b1;
         cmd_done     <= 1'b0;
         busy_timeout <= 1'b0;
         rsp_valid    <= 1'b0;
         rsp_data     <= '0;
      end else begin
         cmd_done     <= 1'b0;
         busy_timeout <= 1'b0;
         rsp_valid    <= 1'b0;
         sh_go        <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               spi_nss <= 1'b1;
               if (cmd_valid && cmd_ready) begin
                  op_q <= cmd_opcode;
                  np_q <= cmd_nparam;
                  nr_q <= cmd_nresp;
                  bcnt <= '0;
                  st   <= ST_WAIT_PRE;
               end
            end
            ST_WAIT_PRE, ST_WAIT_RD: begin
               if (!busy_s) begin
                  spi_nss <= 1'b0;
                  idx     <= '0;
                  st      <= (st == ST_WAIT_PRE) ? ST_SEND : ST_READ;
               end else if (bwait_hit) begin
                  busy_timeout <= 1'b1;
                  st           <= ST_IDLE;
               end else begin
                  bcnt <= bcnt + BCW'(1);
               end
            end
            ST_SEND, ST_READ: begin
               if (sh_done) begin
                  if (st == ST_READ && idx != '0) begin
                     rsp_valid <= 1'b1;
                     rsp_data  <= sh_rx;
                  end
                  idx <= idx + IW'(1);
                  if (idx + IW'(1) == total) begin
                     spi_nss <= 1'b1;
                     gcnt    <= '0;
                     if (st == ST_SEND) begin
                        st <= ST_GAP;
                     end else begin
                        cmd_done <= 1'b1;
                        st       <= ST_IDLE;
                     end
                  end
               end else if (!sh_act && !sh_go) begin
                  sh_go <= 1'b1;
               end
            end
            ST_GAP: begin
               if (gcnt == GW'(GAPC - 1)) begin
                  bcnt <= '0;
                  st   <= (nr_q != '0) ? ST_WAIT_RD : ST_WAIT_POST;
               end else begin
                  gcnt <= gcnt + GW'(1);
               end
            end
            ST_WAIT_POST: begin
               if (!busy_s) begin
                  cmd_done <= 1'b1;
                  st       <= ST_IDLE;
               end else if (bwait_hit) begin
                  busy_timeout <= 1'b1;
                  st           <= ST_IDLE;
               end else begin
                  bcnt <= bcnt + BCW'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_NSS_AFTER_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_nss) |-> $past(!busy_s)); // R4
   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      spi_nss |-> !spi_sck); // R8
   AST_RSP_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!spi_nss)); // R7
   AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_done && busy_timeout)); // R10
   AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready); // R2
   AST_NO_CMD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_rst_n |-> !cmd_ready); // R1
   AST_TIMEOUT_NSS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      busy_timeout |-> spi_nss); // R9

endmodule

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
   localparam int unsigned CLK_DIV    = 2;
   localparam int unsigned MAX_PARAMS = 6;
   localparam int unsigned MAX_RESP   = 5;
   localparam int unsigned BUSY_LIMIT = 60;
   localparam int unsigned CLK_KHZ    = 4;
   localparam int unsigned LOW_EXP    = CLK_KHZ * 10;
   localparam int unsigned WAIT_EXP   = CLK_KHZ * 20;
   localparam int unsigned PCW = $clog2(MAX_PARAMS + 1);
   localparam int unsigned RCW = $clog2(MAX_RESP + 1);
   localparam int unsigned PAW = $clog2(MAX_PARAMS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dev_reset_req = 1'b0;
   logic cmd_valid = 1'b0;
   logic cmd_ready;
   logic [15:0] cmd_opcode = '0;
   logic [PCW-1:0] cmd_nparam = '0;
   logic [RCW-1:0] cmd_nresp = '0;
   logic prm_we = 1'b0;
   logic [PAW-1:0] prm_addr = '0;
   logic [7:0] prm_wdata = '0;
   logic rsp_valid, cmd_done, busy_timeout;
   logic [7:0] rsp_data;
   logic spi_sck, spi_mosi, spi_nss, dev_rst_n;
   logic spi_miso = 1'b0;
   logic dev_busy;

   always #2 clk = ~clk;

   spi_cmd_engine #(
      .CLK_DIV(CLK_DIV), .MAX_PARAMS(MAX_PARAMS), .MAX_RESP(MAX_RESP),
      .BUSY_LIMIT(BUSY_LIMIT), .CLK_KHZ(CLK_KHZ), .RST_LOW_MS(10),
      .RST_WAIT_MS(20), .SYNC_STAGES(2)
   ) u_spi_cmd_engine (
      .clk(clk), .rst_n(rst_n), .dev_reset_req(dev_reset_req),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
      .cmd_nparam(cmd_nparam), .cmd_nresp(cmd_nresp), .prm_we(prm_we),
      .prm_addr(prm_addr), .prm_wdata(prm_wdata), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .cmd_done(cmd_done), .busy_timeout(busy_timeout),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_nss(spi_nss), .dev_busy(dev_busy), .dev_rst_n(dev_rst_n)
   );

   int nchk = 0, nerr = 0, cyc = 0;
   bit finished = 1'b0;

   task automatic check(string req, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(int k);
      return 8'(8'h3C + k * 29);
   endfunction

   function automatic logic [7:0] pval(logic [15:0] op, int i);
      return 8'(op[7:0] + 8'(i * 17 + 3));
   endfunction

   // device model: BUSY after each frame, optional forced BUSY
   int blen = 0, bdev = 0;
   bit busy_force = 1'b0;
   logic prev_nss = 1'b1;
   assign dev_busy = busy_force || (bdev > 0);
   always @(posedge clk) begin
      cyc <= cyc + 1;
      prev_nss <= spi_nss;
      if (spi_nss && !prev_nss) bdev <= blen;
      else if (bdev > 0) bdev <= bdev - 1;
   end

   // device model: MISO pattern and MOSI capture
   int mbyte = 0, mbit = 0, sb = 0, ncap = 0, frames = 0;
   logic [7:0] sh = '0;
   logic [7:0] cap [2048];
   int fstart [512];
   always @(negedge spi_nss) begin
      fstart[frames] = ncap;
      frames++;
      mbyte = 0; mbit = 0; sb = 0;
      spi_miso = pat(0)[7];
   end
   always @(negedge spi_sck) if (!spi_nss) begin
      mbit++;
      if (mbit == 8) begin mbit = 0; mbyte++; end
      spi_miso = pat(mbyte)[7 - mbit];
   end
   always @(posedge spi_sck) if (!spi_nss) begin
      sh = {sh[6:0], spi_mosi};
      sb++;
      if (sb == 8) begin cap[ncap] = sh; ncap++; sb = 0; end
   end

   // output monitors, sampled on the falling clock edge
   int ndone = 0, ntmo = 0, nrsp = 0, done_busy = 0, sck_idle_bad = 0, both = 0;
   int rsp_at_done = 0;
   logic [7:0] rbuf [2048];
   always @(negedge clk) if (rst_n) begin
      if (rsp_valid) begin rbuf[nrsp] = rsp_data; nrsp++; end
      if (cmd_done) begin ndone++; rsp_at_done = nrsp; if (dev_busy) done_busy++; end
      if (busy_timeout) ntmo++;
      if (cmd_done && busy_timeout) both++;
      if (spi_nss && spi_sck) sck_idle_bad++;
   end

   task automatic issue(logic [15:0] op, int np, int nr, output int acc);
      for (int i = 0; i < np; i++) begin
         @(negedge clk);
         prm_we = 1'b1; prm_addr = PAW'(i); prm_wdata = pval(op, i);
      end
      @(negedge clk);
      prm_we = 1'b0;
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_opcode = op;
      cmd_nparam = PCW'(np); cmd_nresp = RCW'(nr);
      @(negedge clk);
      acc = cyc;
      cmd_valid = 1'b0;
   endtask

   task automatic wait_end(int d0, int t0);
      while (ndone == d0 && ntmo == t0) @(negedge clk);
      repeat (4) @(negedge clk);
      while (dev_busy) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   task automatic run_cmd(int np, int nr, int bl);
      logic [15:0] op;
      int f0, c0, r0, d0, t0, acc;
      op = {8'(np * 37 + 5), 8'(nr * 53 + 200)};
      blen = bl;
      f0 = frames; c0 = ncap; r0 = nrsp; d0 = ndone; t0 = ntmo;
      issue(op, np, nr, acc);
      wait_end(d0, t0);
      check("R10 done count", ndone - d0, 1);
      check("R10 timeout count", ntmo - t0, 0);
      check("R6 frame count", frames - f0, (nr > 0) ? 2 : 1);
      check("R3 opcode high byte", cap[c0], op[15:8]);
      check("R3 opcode low byte", cap[c0 + 1], op[7:0]);
      if (np == 0) check("R11 opcode-only frame length", fstart[f0 + 1 < 512 ? f0 : 0] + 2 - c0, 2);
      for (int i = 0; i < np; i++)
         check("R3 parameter byte", cap[c0 + 2 + i], pval(op, i));
      if (nr > 0) begin
         check("R6 read frame start", fstart[f0 + 1], c0 + 2 + np);
         for (int i = 0; i <= nr; i++)
            check("R6 read frame fill byte", cap[c0 + 2 + np + i], 0);
         check("R7 response count", nrsp - r0, nr);
         check("R7 last byte with done", rsp_at_done - r0, nr);
         for (int i = 0; i < nr; i++)
            check("R7 response byte", rbuf[r0 + i], pat(i + 1));
      end else begin
         check("R5 write frame length", ncap - c0, 2 + np);
         check("R7 no response on write", nrsp - r0, 0);
      end
   endtask

   initial begin
      int lowc, waitc, f0, r0, d0, t0, acc;
      // reset state
      repeat (3) @(negedge clk);
      check("R1 dev reset low in reset", dev_rst_n, 0);
      check("R2 not ready in reset", cmd_ready, 0);
      check("R8 nss high in reset", spi_nss, 1);
      check("R8 sck low in reset", spi_sck, 0);
      cmd_valid = 1'b1; cmd_opcode = 16'hBEEF;
      rst_n = 1'b1;
      lowc = 0;
      @(negedge clk);
      while (!dev_rst_n) begin lowc++; @(negedge clk); end
      check("R1 reset hold length", (lowc >= LOW_EXP - 1 && lowc <= LOW_EXP + 1) ? 1 : 0, 1);
      waitc = 0;
      while (!cmd_ready) begin waitc++; @(negedge clk); end
      check("R1 settle length", (waitc >= WAIT_EXP - 1 && waitc <= WAIT_EXP + 1) ? 1 : 0, 1);
      check("R2 no frame while not ready", frames, 0);
      cmd_valid = 1'b0;
      repeat (4) @(negedge clk);

      // sweep all parameter/response pairings
      for (int np = 0; np <= int'(MAX_PARAMS); np++)
         for (int nr = 0; nr <= int'(MAX_RESP); nr++)
            run_cmd(np, nr, ((np + nr) % 3) * 9);

      // BUSY held before the first frame
      busy_force = 1'b1;
      repeat (4) @(negedge clk);
      f0 = frames; d0 = ndone; t0 = ntmo;
      issue(16'h0A0B, 2, 1, acc);
      while (ntmo == t0 && ndone == d0) @(negedge clk);
      check("R9 pre-frame timeout pulse", ntmo - t0, 1);
      check("R9 timeout delay in range",
            (cyc - acc >= int'(BUSY_LIMIT) && cyc - acc <= int'(BUSY_LIMIT) + 6) ? 1 : 0, 1);
      check("R4 no frame under BUSY", frames - f0, 0);
      check("R10 no done with timeout", ndone - d0, 0);
      busy_force = 1'b0;
      repeat (8) @(negedge clk);

      // BUSY held before the read frame
      f0 = frames; r0 = nrsp; d0 = ndone; t0 = ntmo;
      blen = 300;
      issue(16'h0C0D, 1, 3, acc);
      wait_end(d0, t0);
      check("R9 read-wait timeout pulse", ntmo - t0, 1);
      check("R9 only first frame sent", frames - f0, 1);
      check("R9 no response after timeout", nrsp - r0, 0);
      check("R10 no done on read timeout", ndone - d0, 0);
      blen = 0;

      // requested device reset
      @(negedge clk);
      dev_reset_req = 1'b1;
      @(negedge clk);
      dev_reset_req = 1'b0;
      @(negedge clk);
      check("R1 requested reset drives low", dev_rst_n, 0);
      check("R1 not ready during reset", cmd_ready, 0);
      lowc = 1;
      while (!dev_rst_n) begin lowc++; @(negedge clk); end
      check("R1 requested hold length", (lowc >= LOW_EXP - 1 && lowc <= LOW_EXP + 2) ? 1 : 0, 1);
      while (!cmd_ready) @(negedge clk);
      run_cmd(3, 2, 5);

      check("R5 done never under BUSY", done_busy, 0);
      check("R8 sck idle low", sck_idle_bad, 0);
      check("R10 never both pulses", both, 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

endmodule